// File: doc/BRIEF.md
# Cartridge Save-Memory Mapper with Device Autodetect

This block sits on a 24-bit CPU address bus and decodes accesses to a cartridge's battery-backed save memory. It holds a two-bit control register (mapping enable and write protect) and works out for itself which kind of save device the cartridge carries. The first write into the save window decides this. A write to the two-byte pair at the window base selects a serial EEPROM. Any other write selects byte-wide SRAM. A read above that pair while mapping is enabled also settles the choice on SRAM. Once a type is chosen, only reset clears it.

In SRAM mode the block drives a byte-wide SRAM request port. It suppresses writes that would not change the stored byte and raises a sticky dirty flag when one does. In EEPROM mode the save window shrinks to the two-byte pair, and writes carry SDA/SCL line levels toward a serial protocol engine outside this block. Line updates that arrive in quick succession, measured by a CPU cycle counter input, are merged into a pending state. They are not passed through one by one.

Top module: `savemem_mapper`

## Requirements
- R1: After reset the control register is 0, the device type is undetected, `save_dirty` is 0, `ee_upd` is 0, and both `ee_sda` and `ee_scl` are 1.
- R2: A byte write (bus_word=0) to address 0xA130F1 loads the control register from write-data bits 1..0: bit 0 enables mapping, bit 1 write-protects SRAM. Writes to any other address leave the register unchanged.
- R3: A read is serviced (`bus_hit`=1, data driven) only when its address lies in the active save window and either mapping is enabled or EEPROM mode is selected. Any other read returns `bus_hit`=0 and `bus_rdata`=0.
- R4: If the device is undetected and a write hits 0x200000 or 0x200001, EEPROM mode is selected. From then on the window covers only those two addresses.
- R5: If the device is undetected, any other write in the window (default 0x200000..0x20FFFF) selects SRAM mode. The selected mode is then held until reset.
- R6: A read at an address above 0x200001, while mapping is enabled and the device is undetected, selects SRAM mode. A later write to 0x200000 then goes to SRAM.
- R7: In SRAM mode, `sram_we` is asserted only when write protect is clear and the new byte differs from the byte read back on `sram_rdata`. The same write sets `save_dirty`, which stays set until reset.
- R8: Word accesses use the even address (bit 0 forced to 0). A word read returns the save byte in both halves. A byte read returns it in bits 7..0 with bits 15..8 zero. A word write stores write-data bits 15..8, and a byte write stores bits 7..0.
- R9: In EEPROM mode, write-data bit 0 is SDA and bit 1 is SCL. A write whose `cyc_count` is fewer than 16 counts past the last timestamp only replaces the pending SDA/SCL pair.
- R10: Any other EEPROM write first commits the pending pair to `ee_sda`/`ee_scl`, with a one-cycle `ee_upd` pulse after the write edge, and then stores the new pair as pending. The timestamp takes `cyc_count` only if the committed lines changed.
- R11: An EEPROM-mode read returns the `ee_sdo` input in bit 0 of the byte, which is duplicated for word reads like any save byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | A bus access is present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_addr | input | 24 | CPU byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| bus_hit | output | 1 | The read is serviced by the save memory |
| cyc_count | input | 32 | Free-running CPU cycle counter |
| sram_req | output | 1 | SRAM access request |
| sram_we | output | 1 | SRAM byte write enable |
| sram_addr | output | 24 | SRAM byte address |
| sram_wdata | output | 8 | SRAM write byte |
| sram_rdata | input | 8 | SRAM read byte, combinational from sram_addr |
| save_dirty | output | 1 | Sticky flag: save contents changed |
| ee_sdo | input | 1 | Serial data returned by the EEPROM engine |
| ee_sda | output | 1 | Committed SDA level |
| ee_scl | output | 1 | Committed SCL level |
| ee_upd | output | 1 | One-cycle pulse when a line pair is committed |

## Verification
The assertions take as given that `sram_rdata` reflects the byte at `sram_addr` within the same cycle. They also assume the bus presents at most one access per cycle, and that `cyc_count` moves forward by less than half its range between EEPROM writes, so the wrapped difference is a true gap. The stimulus holds `bus_valid` for a single cycle per access and drives a combinational byte model behind the SRAM port. It raises `cyc_count` monotonically in small steps, and it places writes exactly 15 and 16 counts apart to straddle the merge threshold.

// File: rtl/savemem_pkg.sv
`timescale 1ns/1ps
package savemem_pkg;
   typedef enum logic [1:0] {
      DEV_UNKNOWN = 2'd0,
      DEV_SRAM    = 2'd1,
      DEV_EEPROM  = 2'd2
   } dev_kind_e;

   typedef struct packed {
      logic sda;
      logic scl;
   } ee_pair_t;
endpackage

// File: rtl/savemem_ctrl_reg.sv
`timescale 1ns/1ps
module savemem_ctrl_reg #(
   parameter int          ADDR_W    = 24,
   parameter logic [31:0] CTRL_ADDR = 32'h00A1_30F1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        wbits,
   output logic              map_en,
   output logic              wprot
);
   localparam logic [ADDR_W-1:0] CTRL_A = CTRL_ADDR[ADDR_W-1:0];

   logic [1:0] ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl_q <= '0;
      else if (byte_wr && (addr == CTRL_A))
         ctrl_q <= wbits;
   end

   assign map_en = ctrl_q[0];
   assign wprot  = ctrl_q[1];
endmodule

// File: rtl/savemem_detect.sv
`timescale 1ns/1ps
module savemem_detect
   import savemem_pkg::*;
#(
   parameter int          ADDR_W  = 24,
   parameter logic [31:0] WIN_LO  = 32'h0020_0000,
   parameter logic [31:0] WIN_HI  = 32'h0020_FFFF,
   parameter logic [31:0] EE_ADDR = 32'h0020_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              map_en,
   output dev_kind_e         dev,
   output logic              in_win,
   output logic              eff_ee,
   output logic              read_ok
);
   localparam logic [ADDR_W-1:0] WLO  = WIN_LO[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] WHI  = WIN_HI[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] EEHI = {EE_ADDR[ADDR_W-1:1], 1'b1};

   dev_kind_e dev_q;
   logic      ee_pair, full_win, undet;

   assign ee_pair  = (acc_addr[ADDR_W-1:1] == EE_ADDR[ADDR_W-1:1]);
   assign full_win = (acc_addr >= WLO) && (acc_addr <= WHI);
   assign undet    = (dev_q == DEV_UNKNOWN);
   assign in_win   = (dev_q == DEV_EEPROM) ? ee_pair : full_win;
   assign eff_ee   = (dev_q == DEV_EEPROM) || (undet && acc_write && ee_pair);
   assign read_ok  = in_win && (map_en || (dev_q == DEV_EEPROM));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dev_q <= DEV_UNKNOWN;
      else if (undet && acc_valid && in_win) begin
         if (acc_write)
            dev_q <= ee_pair ? DEV_EEPROM : DEV_SRAM;
         else if (map_en && (acc_addr > EEHI))
            dev_q <= DEV_SRAM;
      end
   end

   assign dev = dev_q;
endmodule

// File: rtl/savemem_ee_coalesce.sv
`timescale 1ns/1ps
module savemem_ee_coalesce
   import savemem_pkg::*;
#(
   parameter int CYC_W = 32,
   parameter int GAP   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_stb,
   input  logic             new_sda,
   input  logic             new_scl,
   input  logic [CYC_W-1:0] now,
   output logic             line_sda,
   output logic             line_scl,
   output logic             upd
);
   ee_pair_t         pend_q, line_q;
   logic [CYC_W-1:0] stamp_q;
   logic             close;

   generate
      if (GAP == 0) begin : g_pass
         assign close = 1'b0;
      end else begin : g_merge
         localparam logic [CYC_W-1:0] GAP_L = CYC_W'(GAP);
         assign close = (now - stamp_q) < GAP_L;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= '{sda: 1'b1, scl: 1'b1};
         line_q  <= '{sda: 1'b1, scl: 1'b1};
         stamp_q <= '0;
         upd     <= 1'b0;
      end else begin
         upd <= 1'b0;
         if (wr_stb) begin
            pend_q <= '{sda: new_sda, scl: new_scl};
            if (!close) begin
               line_q <= pend_q;
               upd    <= 1'b1;
               if (pend_q != line_q)
                  stamp_q <= now;
            end
         end
      end
   end

   assign line_sda = line_q.sda;
   assign line_scl = line_q.scl;
endmodule

// File: rtl/savemem_mapper.sv
`timescale 1ns/1ps
module savemem_mapper
   import savemem_pkg::*;
#(
   parameter int          ADDR_W    = 24,
   parameter int          BYTE_W    = 8,
   parameter int          CYC_W     = 32,
   parameter logic [31:0] WIN_LO    = 32'h0020_0000,
   parameter logic [31:0] WIN_HI    = 32'h0020_FFFF,
   parameter logic [31:0] EE_ADDR   = 32'h0020_0000,
   parameter logic [31:0] CTRL_ADDR = 32'h00A1_30F1,
   parameter int          EE_GAP    = 16,
   parameter int          SDA_BIT   = 0,
   parameter int          SCL_BIT   = 1,
   parameter bit          DUP_WORD  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_valid,
   input  logic                bus_write,
   input  logic                bus_word,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [2*BYTE_W-1:0] bus_wdata,
   output logic [2*BYTE_W-1:0] bus_rdata,
   output logic                bus_hit,
   input  logic [CYC_W-1:0]    cyc_count,
   output logic                sram_req,
   output logic                sram_we,
   output logic [ADDR_W-1:0]   sram_addr,
   output logic [BYTE_W-1:0]   sram_wdata,
   input  logic [BYTE_W-1:0]   sram_rdata,
   output logic                save_dirty,
   input  logic                ee_sdo,
   output logic                ee_sda,
   output logic                ee_scl,
   output logic                ee_upd
);
   localparam int WORD_W = 2 * BYTE_W;

   generate
      if (ADDR_W < 2 || ADDR_W > 32) begin : g_bad_aw
         $error("savemem_mapper: ADDR_W out of range");
      end
      if (WIN_LO > WIN_HI) begin : g_bad_win
         $error("savemem_mapper: window bounds reversed");
      end
      if (EE_ADDR < WIN_LO || ({EE_ADDR[31:1], 1'b1}) > WIN_HI) begin : g_bad_ee
         $error("savemem_mapper: EEPROM pair outside window");
      end
      if (CTRL_ADDR >= WIN_LO && CTRL_ADDR <= WIN_HI) begin : g_bad_ctrl
         $error("savemem_mapper: control address inside window");
      end
      if (SDA_BIT == SCL_BIT || SDA_BIT >= BYTE_W || SCL_BIT >= BYTE_W) begin : g_bad_bits
         $error("savemem_mapper: line bit positions invalid");
      end
   endgenerate

   logic [ADDR_W-1:0] acc_addr;
   logic [BYTE_W-1:0] wr_byte, rd_byte;
   logic              is_wr, is_rd;
   logic              map_en, wprot;
   dev_kind_e         dev_st;
   logic              in_win, eff_ee, read_ok;
   logic              sram_path, ee_stb, dirty_q;

   assign acc_addr = bus_word ? {bus_addr[ADDR_W-1:1], 1'b0} : bus_addr;
   assign wr_byte  = bus_word ? bus_wdata[WORD_W-1:BYTE_W] : bus_wdata[BYTE_W-1:0];
   assign is_wr    = bus_valid && bus_write;
   assign is_rd    = bus_valid && !bus_write;

   savemem_ctrl_reg #(
      .ADDR_W    (ADDR_W),
      .CTRL_ADDR (CTRL_ADDR)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .byte_wr (is_wr && !bus_word && !in_win),
      .addr    (acc_addr),
      .wbits   (bus_wdata[1:0]),
      .map_en  (map_en),
      .wprot   (wprot)
   );

   savemem_detect #(
      .ADDR_W  (ADDR_W),
      .WIN_LO  (WIN_LO),
      .WIN_HI  (WIN_HI),
      .EE_ADDR (EE_ADDR)
   ) u_det (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_valid (bus_valid),
      .acc_write (bus_write),
      .acc_addr  (acc_addr),
      .map_en    (map_en),
      .dev       (dev_st),
      .in_win    (in_win),
      .eff_ee    (eff_ee),
      .read_ok   (read_ok)
   );

   // SRAM steering
   assign sram_path  = bus_valid && in_win && !eff_ee && (bus_write || read_ok);
   assign sram_req   = sram_path;
   assign sram_addr  = acc_addr;
   assign sram_wdata = wr_byte;
   assign sram_we    = sram_path && bus_write && !wprot && (sram_rdata != wr_byte);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dirty_q <= 1'b0;
      else if (sram_we)
         dirty_q <= 1'b1;
   end
   assign save_dirty = dirty_q;

   // EEPROM line path
   assign ee_stb = is_wr && in_win && eff_ee;

   savemem_ee_coalesce #(
      .CYC_W (CYC_W),
      .GAP   (EE_GAP)
   ) u_ee (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_stb   (ee_stb),
      .new_sda  (wr_byte[SDA_BIT]),
      .new_scl  (wr_byte[SCL_BIT]),
      .now      (cyc_count),
      .line_sda (ee_sda),
      .line_scl (ee_scl),
      .upd      (ee_upd)
   );

   // Read return
   assign rd_byte = eff_ee ? {{(BYTE_W-1){1'b0}}, ee_sdo} : sram_rdata;
   assign bus_hit = is_rd && read_ok;

   generate
      if (DUP_WORD) begin : g_dup
         assign bus_rdata = !bus_hit ? '0
                          : (bus_word ? {rd_byte, rd_byte} : {{BYTE_W{1'b0}}, rd_byte});
      end else begin : g_low
         assign bus_rdata = !bus_hit ? '0 : {{BYTE_W{1'b0}}, rd_byte};
      end
   endgenerate
endmodule

// File: rtl/savemem_mapper_chk.sv
`timescale 1ns/1ps
module savemem_mapper_chk #(
   parameter int BYTE_W = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_valid,
   input logic                bus_write,
   input logic                bus_word,
   input logic [2*BYTE_W-1:0] bus_rdata,
   input logic                bus_hit,
   input logic                sram_req,
   input logic                sram_we,
   input logic                save_dirty,
   input logic                ee_upd,
   input logic                wprot,
   input logic [1:0]          dev
);
   // R7
   wp_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_write && wprot) |-> !sram_we);
   // R7
   we_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sram_we |-> sram_req);
   // R7
   dirty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      save_dirty |=> save_dirty);
   // R5
   det_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dev != 2'd0) |=> (dev == $past(dev)));
   // R8
   word_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_hit && bus_word) |-> (bus_rdata[2*BYTE_W-1:BYTE_W] == bus_rdata[BYTE_W-1:0]));
   // R3
   hit_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_hit |-> (bus_valid && !bus_write));
   // R3
   miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_hit |-> (bus_rdata == '0));
   // R10
   upd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ee_upd |-> $past(bus_valid && bus_write));
endmodule

bind savemem_mapper savemem_mapper_chk #(.BYTE_W(BYTE_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_valid  (bus_valid),
   .bus_write  (bus_write),
   .bus_word   (bus_word),
   .bus_rdata  (bus_rdata),
   .bus_hit    (bus_hit),
   .sram_req   (sram_req),
   .sram_we    (sram_we),
   .save_dirty (save_dirty),
   .ee_upd     (ee_upd),
   .wprot      (wprot),
   .dev        (dev_st)
);

// File: tb/savemem_mapper_test.sv
`timescale 1ns/1ps
module savemem_mapper_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0, bus_write = 1'b0, bus_word = 1'b0;
   logic [23:0] bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        bus_hit;
   logic [31:0] cyc_count = '0;
   logic        sram_req, sram_we, save_dirty;
   logic [23:0] sram_addr;
   logic [7:0]  sram_wdata, sram_rdata;
   logic        ee_sdo = 1'b1;
   logic        ee_sda, ee_scl, ee_upd;

   int checks = 0;
   int errors = 0;
   logic        s_hit, s_we, s_req;
   logic [15:0] s_rdata;
   logic [7:0]  mem [256];

   always #2.5 clk = ~clk;

   savemem_mapper uut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_hit(bus_hit), .cyc_count(cyc_count),
      .sram_req(sram_req), .sram_we(sram_we), .sram_addr(sram_addr),
      .sram_wdata(sram_wdata), .sram_rdata(sram_rdata), .save_dirty(save_dirty),
      .ee_sdo(ee_sdo), .ee_sda(ee_sda), .ee_scl(ee_scl), .ee_upd(ee_upd)
   );

   assign sram_rdata = mem[sram_addr[7:0]];
   always_ff @(posedge clk) if (sram_we) mem[sram_addr[7:0]] <= sram_wdata;

   typedef struct packed {
      logic        wr;
      logic        wd;
      logic [23:0] a;
      logic [15:0] d;
      logic        chk;
      logic        hit;
      logic [15:0] rd;
   } vec_t;

   localparam vec_t VEC [14] = '{
      '{1'b1, 1'b0, 24'hA130F3, 16'h0001, 1'b0, 1'b0, 16'h0000}, // R2 wrong address
      '{1'b0, 1'b0, 24'h200010, 16'h0000, 1'b1, 1'b0, 16'h0000}, // R2 R3 still disabled
      '{1'b1, 1'b0, 24'hA130F1, 16'h0001, 1'b0, 1'b0, 16'h0000}, // R2 enable
      '{1'b0, 1'b0, 24'h200010, 16'h0000, 1'b1, 1'b1, 16'h0000}, // R3 R6 read detects SRAM
      '{1'b1, 1'b0, 24'h200000, 16'h005A, 1'b0, 1'b0, 16'h0000}, // R6 goes to SRAM
      '{1'b0, 1'b1, 24'h200000, 16'h0000, 1'b1, 1'b1, 16'h5A5A}, // R6 R8
      '{1'b0, 1'b1, 24'h200001, 16'h0000, 1'b1, 1'b1, 16'h5A5A}, // R8 aligned
      '{1'b0, 1'b0, 24'h200001, 16'h0000, 1'b1, 1'b1, 16'h0000}, // R8 byte
      '{1'b1, 1'b0, 24'hA130F1, 16'h0003, 1'b0, 1'b0, 16'h0000}, // R2 protect
      '{1'b1, 1'b0, 24'h200000, 16'h0011, 1'b0, 1'b0, 16'h0000}, // R7 dropped
      '{1'b0, 1'b0, 24'h200000, 16'h0000, 1'b1, 1'b1, 16'h005A}, // R7 unchanged
      '{1'b0, 1'b0, 24'h300000, 16'h0000, 1'b1, 1'b0, 16'h0000}, // R3 outside
      '{1'b1, 1'b0, 24'hA130F1, 16'h0000, 1'b0, 1'b0, 16'h0000}, // R2 disable
      '{1'b0, 1'b0, 24'h200000, 16'h0000, 1'b1, 1'b0, 16'h0000}  // R2 R3 disabled
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic access(input logic wr, input logic wd, input logic [23:0] a,
                         input logic [15:0] d, input logic [31:0] cyc);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = wr; bus_word = wd;
      bus_addr = a; bus_wdata = d; cyc_count = cyc;
      #1;
      s_hit = bus_hit; s_rdata = bus_rdata; s_we = sram_we; s_req = sram_req;
      @(posedge clk);
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0; bus_word = 1'b0;
   endtask

   task automatic ee_step(input logic [7:0] d, input logic [31:0] cyc,
                          input logic eu, input logic es, input logic ec, input string req);
      access(1'b1, 1'b0, 24'h200001, {8'h00, d}, cyc);
      check(req, {29'd0, ee_upd, ee_sda, ee_scl}, {29'd0, eu, es, ec});
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      do_reset();
      // R1 reset state
      check("R1", {28'd0, save_dirty, ee_upd, ee_sda, ee_scl}, 32'h3);
      bus_valid = 1'b1; bus_addr = 24'h200010; #1;
      check("R1", {15'd0, bus_hit, bus_rdata}, 32'h0);
      bus_valid = 1'b0;

      for (int i = 0; i < 14; i++) begin
         access(VEC[i].wr, VEC[i].wd, VEC[i].a, VEC[i].d, 32'd0);
         if (VEC[i].chk)
            check($sformatf("R3 vector %0d", i), {15'd0, s_hit, s_rdata},
                  {15'd0, VEC[i].hit, VEC[i].rd});
      end

      // R7 dirty and write suppression, R5 SRAM kept
      do_reset();
      access(1'b1, 1'b0, 24'h200004, 16'h0000, 32'd0);
      check("R7 same byte", {30'd0, s_we, save_dirty}, 32'h0);
      access(1'b1, 1'b0, 24'h200004, 16'h0077, 32'd0);
      check("R7 new byte", {30'd0, s_we, save_dirty}, 32'h3);
      access(1'b1, 1'b0, 24'h200004, 16'h0077, 32'd0);
      check("R7 sticky", {30'd0, s_we, save_dirty}, 32'h1);
      access(1'b1, 1'b1, 24'h200001, 16'h22AA, 32'd0);
      access(1'b1, 1'b0, 24'hA130F1, 16'h0001, 32'd0);
      access(1'b0, 1'b1, 24'h200000, 16'h0000, 32'd0);
      check("R5 R8 word write high byte", {15'd0, s_hit, s_rdata}, {15'd0, 1'b1, 16'h2222});

      // R4 R9 R10 R11 EEPROM
      do_reset();
      ee_step(8'h00, 32'd100, 1'b1, 1'b1, 1'b1, "R4 R10 first commit");
      ee_step(8'h03, 32'd105, 1'b1, 1'b0, 1'b0, "R10 commit pending");
      ee_step(8'h01, 32'd110, 1'b0, 1'b0, 1'b0, "R9 merged");
      ee_step(8'h02, 32'd120, 1'b0, 1'b0, 1'b0, "R9 gap 15");
      ee_step(8'h00, 32'd121, 1'b1, 1'b0, 1'b1, "R10 gap 16");
      ee_step(8'h03, 32'd140, 1'b1, 1'b0, 1'b0, "R10 commit");
      ee_step(8'h00, 32'd150, 1'b0, 1'b0, 1'b0, "R9 merged");
      ee_step(8'h00, 32'd160, 1'b1, 1'b0, 1'b0, "R10 same lines");
      ee_step(8'h03, 32'd165, 1'b1, 1'b0, 1'b0, "R10 stamp kept");
      access(1'b0, 1'b0, 24'h200000, 16'h0000, 32'd170);
      check("R11 byte", {15'd0, s_hit, s_rdata}, {15'd0, 1'b1, 16'h0001});
      access(1'b0, 1'b1, 24'h200000, 16'h0000, 32'd171);
      check("R11 word", {15'd0, s_hit, s_rdata}, {15'd0, 1'b1, 16'h0101});
      access(1'b0, 1'b0, 24'h200002, 16'h0000, 32'd172);
      check("R4 window shrink read", {15'd0, s_hit, s_rdata}, 32'h0);
      access(1'b1, 1'b0, 24'h200004, 16'h0055, 32'd173);
      check("R4 window shrink write", {30'd0, s_req, s_we}, 32'h0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule